// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block runs on the host side of a parallel flash memory after a program or erase command has already gone out. It watches the device's status byte through a simple request/response bus and reports whether the operation succeeded. A one-cycle `start` pulse captures three things: the method, the address to poll, and the expected value of bit 7. The address is the programmed location, or any location inside a block being erased. For an erase, the expected bit 7 is 1.

Two methods are available. The toggle method reads the status twice and compares bit 6 between the two reads. The data method compares bit 7 against the expected value. The error flag in bit 5 can rise in the same moment the operation finishes, so both methods check once more after they see it. If the outcome is a failure, the poller writes the reset-to-read command to the device before it reports. A timeout counter bounds the whole poll and turns an expiry into a failure.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is held, and afterwards until a start pulse arrives, `req_valid`, `done`, `pass` and `fail` are all 0.
- R2: With `mode`=0 (toggle), the poller issues status reads in pairs at the captured address. If bit 6 has the same value in both reads of a pair, the result is pass.
- R3: In toggle mode, if bit 6 differs between the two reads and bit 5 of the second read is 0, another pair of reads follows.
- R4: In toggle mode, if bit 6 differs and bit 5 of the second read is 1, exactly two more reads follow. If bit 6 matches across those two, the result is pass; otherwise it is fail.
- R5: With `mode`=1 (data), each read compares bit 7 with `exp_d7`. A match gives pass. A mismatch with bit 5 = 0 starts another read.
- R6: In data mode, a mismatch with bit 5 = 1 is followed by exactly one more read. A bit-7 match on that read gives pass; otherwise the result is fail.
- R7: A fail result is preceded by one write (`req_write`=1) of 8'hF0 to the captured address, and `done` rises in the cycle after that write's response. A pass result issues no write.
- R8: If the poll lasts `TMO_CYCLES` cycles without a result, the poller abandons it, performs the R7 write and reports fail.
- R9: A request keeps `req_valid`, `req_addr` and `req_write` stable until `rsp_valid` arrives. Read data is only used in a cycle where `rsp_valid` is 1.
- R10: `done` is a one-cycle pulse. When it is high, exactly one of `pass` and `fail` is high, and that flag stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted when idle) |
| mode | input | 1 | 0 = toggle method, 1 = data method |
| poll_addr | input | AW | Address that is polled |
| exp_d7 | input | 1 | Expected bit 7 for the data method |
| req_valid | output | 1 | Bus request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Request address |
| req_wdata | output | DW | Write data (reset-to-read command) |
| rsp_valid | input | 1 | Response/acknowledge for the pending request |
| rsp_rdata | input | DW | Read data, valid with rsp_valid |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded |
| fail | output | 1 | Operation failed or timed out |

## Verification
The hardest cases to reach are the error-recheck paths. In those paths, the read that shows bit 5 set must be followed by one more read (data method) or two more reads (toggle method), and that final read alone decides pass or fail. The bench drives these paths with a scripted bus responder that returns a prepared sequence of status bytes, one per read. Each script sets bit 5 exactly on the read that should trigger the recheck, then either settles or keeps changing. The bench checks both the number of reads and whether a reset write appeared. The timeout path uses a responder mode that toggles bit 6 forever with bit 5 clear.

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int TMO_CYCLES = 4000000,
  parameter logic [DW-1:0] RST_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [AW-1:0] poll_addr,
  input  logic          exp_d7,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output logic          done,
  output logic          pass,
  output logic          fail
);
  localparam int TW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_T1, S_T2, S_TE1, S_TE2, S_D1, S_DE, S_WR, S_FIN
  } st_t;

  st_t state, nxt;
  logic [AW-1:0] addr_q;
  logic          exp_q, prev6, pass_q, fail_q;
  logic [TW-1:0] tcnt;
  logic          polling, tmo_hit;

  wire b7    = rsp_rdata[7];
  wire b6    = rsp_rdata[6];
  wire b5    = rsp_rdata[5];
  wire same6 = (b6 == prev6);
  wire hit7  = (b7 == exp_q);

  assign polling = (state == S_T1) || (state == S_T2) || (state == S_TE1) ||
                   (state == S_TE2) || (state == S_D1) || (state == S_DE);
  assign tmo_hit = polling && (tcnt == TW'(TMO_CYCLES - 1));

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (start) nxt = mode ? S_D1 : S_T1;
      S_T1:   if (rsp_valid) nxt = S_T2;
      S_T2:   if (rsp_valid) nxt = same6 ? S_FIN : (b5 ? S_TE1 : S_T1);
      S_TE1:  if (rsp_valid) nxt = S_TE2;
      S_TE2:  if (rsp_valid) nxt = same6 ? S_FIN : S_WR;
      S_D1:   if (rsp_valid) nxt = hit7 ? S_FIN : (b5 ? S_DE : S_D1);
      S_DE:   if (rsp_valid) nxt = hit7 ? S_FIN : S_WR;
      S_WR:   if (rsp_valid) nxt = S_FIN;
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (tmo_hit) nxt = S_WR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      exp_q  <= 1'b0;
      prev6  <= 1'b0;
      tcnt   <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && start) begin
        addr_q <= poll_addr;
        exp_q  <= exp_d7;
        tcnt   <= '0;
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end else if (polling) begin
        tcnt <= tcnt + 1'b1;
      end
      if (rsp_valid && (state == S_T1 || state == S_TE1)) prev6 <= b6;
      if (polling && nxt == S_FIN) pass_q <= 1'b1;
      if (polling && nxt == S_WR)  fail_q <= 1'b1;
    end
  end

  assign req_valid = polling || (state == S_WR);
  assign req_write = (state == S_WR);
  assign req_addr  = addr_q;
  assign req_wdata = RST_CMD;
  assign done      = (state == S_FIN);
  assign pass      = pass_q;
  assign fail      = fail_q;
endmodule

module flash_done_poller_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_write,
  input logic [31:0] req_addr_w,
  input logic rsp_valid,
  input logic done,
  input logic pass,
  input logic fail,
  input logic tmo_hit
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid && !tmo_hit) |=> (req_valid && $stable(req_addr_w) && $stable(req_write)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));
  p_fail_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && rsp_valid) |=> (done && fail));
  p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (req_valid && req_write));
endmodule

bind flash_done_poller flash_done_poller_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr_w(32'(req_addr)), .rsp_valid(rsp_valid), .done(done),
  .pass(pass), .fail(fail), .tmo_hit(tmo_hit)
);

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int TMO = 200;
  localparam int LAT = 2;

  typedef struct packed {
    logic        mode;
    logic        exp7;
    logic [47:0] rd;
    logic        ok;
    logic [3:0]  nrd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 48'h000000000000, 1'b1, 4'd2},
    '{1'b0, 1'b0, 48'h000000000040, 1'b1, 4'd4},
    '{1'b0, 1'b0, 48'h000000002040, 1'b1, 4'd4},
    '{1'b0, 1'b0, 48'h000000402040, 1'b0, 4'd4},
    '{1'b1, 1'b1, 48'h000000000080, 1'b1, 4'd1},
    '{1'b1, 1'b1, 48'h000000800000, 1'b1, 4'd3},
    '{1'b1, 1'b1, 48'h000000802000, 1'b1, 4'd3},
    '{1'b1, 1'b1, 48'h000000002000, 1'b0, 4'd3},
    '{1'b1, 1'b0, 48'h000000000080, 1'b1, 4'd2},
    '{1'b1, 1'b0, 48'h0000000080A0, 1'b0, 4'd2}
  };

  logic clk = 0, rst_n = 0, start = 0, mode = 0, exp_d7 = 0;
  logic [AW-1:0] poll_addr = '0;
  logic req_valid, req_write, done, pass, fail;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid = 0;
  logic [DW-1:0] rsp_rdata = '0;

  always #10 clk = ~clk;

  flash_done_poller #(.AW(AW), .DW(DW), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .poll_addr(poll_addr),
    .exp_d7(exp_d7), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .done(done), .pass(pass), .fail(fail));

  vec_t cur = '0;
  logic forever_toggle = 0;
  int lat_cnt = 0, nrd = 0, nwr = 0, bad_addr = 0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] wr_addr = '0;
  int n_chk = 0, n_err = 0;

  always_ff @(posedge clk) begin
    if (start) begin
      nrd <= 0; nwr <= 0; bad_addr <= 0; lat_cnt <= 0; rsp_valid <= 1'b0;
    end else if (req_valid && !rsp_valid) begin
      if (lat_cnt == LAT) begin
        lat_cnt <= 0;
        rsp_valid <= 1'b1;
        if (req_write) begin
          nwr <= nwr + 1; wr_data <= req_wdata; wr_addr <= req_addr;
          rsp_rdata <= '0;
        end else begin
          nrd <= nrd + 1;
          if (req_addr != poll_addr) bad_addr <= bad_addr + 1;
          if (forever_toggle) rsp_rdata <= nrd[0] ? 8'h40 : 8'h00;
          else rsp_rdata <= cur.rd[8*((nrd > 5) ? 5 : nrd) +: 8];
        end
      end else lat_cnt <= lat_cnt + 1;
    end else begin
      rsp_valid <= 1'b0;
      if (!req_valid) lat_cnt <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic m, input logic e, input logic [AW-1:0] a, output bit got);
    int cyc = 0;
    @(negedge clk);
    mode = m; exp_d7 = e; poll_addr = a; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
    got = done;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    chk("R1 req_valid in reset", 32'(req_valid), 0);
    chk("R1 done in reset", 32'(done), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle req_valid", 32'(req_valid), 0);
    chk("R1 idle pass/fail", {30'd0, pass, fail}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a = AW'(20'h1234 + i * 20'h111);
      cur = VECS[i];
      run(cur.mode, cur.exp7, a, got);
      chk($sformatf("R9 v%0d finished", i), 32'(got), 1);
      chk($sformatf("R2 R5 v%0d pass", i), 32'(pass), 32'(cur.ok));
      chk($sformatf("R4 R6 v%0d fail", i), 32'(fail), 32'(!cur.ok));
      chk($sformatf("R3 R4 R6 v%0d reads", i), 32'(nrd), 32'(cur.nrd));
      chk($sformatf("R2 v%0d read addr", i), 32'(bad_addr), 0);
      chk($sformatf("R7 v%0d writes", i), 32'(nwr), cur.ok ? 0 : 1);
      if (!cur.ok) begin
        chk($sformatf("R7 v%0d write data", i), 32'(wr_data), 32'hF0);
        chk($sformatf("R7 v%0d write addr", i), 32'(wr_addr), 32'(a));
      end
      @(negedge clk);
      chk($sformatf("R10 v%0d done pulse", i), 32'(done), 0);
      repeat (2) @(negedge clk);
      chk($sformatf("R10 v%0d result held", i), {30'd0, pass, fail}, cur.ok ? 2 : 1);
    end

    forever_toggle = 1;
    run(1'b0, 1'b0, 20'hABCDE, got);
    chk("R8 timeout finished", 32'(got), 1);
    chk("R8 timeout fail", 32'(fail), 1);
    chk("R8 timeout pass", 32'(pass), 0);
    chk("R8 timeout reset write", 32'(nwr), 1);
    chk("R8 timeout write data", 32'(wr_data), 32'hF0);
    forever_toggle = 0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule